// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits on a simple host register bus and opens two internal register spaces through a narrow window. One space holds wide configuration and status words for the top-level logic. The other holds byte-wide controller registers. Each space is reached through its own channel of three host registers: one that takes an internal address, one that moves data, and one for control. The host never sees the internal addresses directly. It loads an address into a channel and then moves data through that channel's data register.

The access rules are strict and follow the internal buses. An address only takes effect after it has been written twice in a row with the same value. A read is split into two data-register reads. The first one starts the internal fetch and hands back whatever was fetched before. The second one hands back the fresh contents. A write needs one data-register write. Each channel can be told to flag a bus error when a data access arrives before an address is in place. Without that, such an access is dropped without any response. The two channels keep fully separate state.

Top module: `ixb_bridge`

## Requirements
- R1: Host offsets decode as follows. Offset 0x00 is the top-space address register, 0x04 its data register and 0x08 its control register. Offsets 0x10, 0x14 and 0x18 are the same three registers for the controller space. Any other offset is acknowledged with read data 0 and no error, and causes no internal access.
- R2: Each host access cycle (host_sel high) is acknowledged by host_ack exactly one cycle later, together with host_rdata and host_err. host_ack stays low in every other cycle.
- R3: An address-register write keeps only the low 16 bits. The channel becomes armed only when two consecutive address writes carry the same 16-bit value. A differing value restarts the count. Control-register accesses and address reads between the two writes do not break the pair. Reading the address register returns the latched 16 bits, zero-extended.
- R4: A data access on a channel that is not armed makes no internal access and returns read data 0. host_err is 1 if that channel's error-enable bit is set, and 0 otherwise. If only one address write had been made, the pending pair is discarded.
- R5: A data write on an armed channel raises that space's write strobe for that same cycle, with the armed address and the host data. The controller space receives only bits 7:0 of the host data.
- R6: On an armed channel, data reads alternate between two kinds. A launching read raises the read strobe in the same cycle and returns the previously fetched value (0 after reset). The following read returns the value fetched by that launch and makes no internal access. Any address write or data write makes the next read a launching read.
- R7: Control-register bit 15 is the error-enable bit. It is written from host bit 15 and reads back at bit 15, with every other bit reading as 0. Control accesses leave address and read sequencing untouched.
- R8: The two channels keep independent address, arming, read-phase, fetch and error-enable state. At most one internal strobe is active in any cycle.
- R9: After reset, no channel is armed, error reporting is disabled, the fetched values are 0, and host_ack and all internal strobes are low.
- R10: Data read from the controller space is returned zero-extended from 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | Access acknowledge, one cycle after host_sel |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_err | output | 1 | Bus error response, valid with host_ack |
| top_rd | output | 1 | Top-space read strobe |
| top_wr | output | 1 | Top-space write strobe |
| top_addr | output | 16 | Top-space register address |
| top_wdata | output | 32 | Top-space write data |
| top_rdata | input | 32 | Top-space read data, combinational from top_addr |
| ctl_rd | output | 1 | Controller-space read strobe |
| ctl_wr | output | 1 | Controller-space write strobe |
| ctl_addr | output | 16 | Controller-space register address |
| ctl_wdata | output | 8 | Controller-space write data |
| ctl_rdata | input | 8 | Controller-space read data, combinational from ctl_addr |

## Verification
The assertions assume that host_sel is a single-cycle request that the host does not rely on for back-pressure. They also assume that both internal spaces answer a read strobe combinationally in the same cycle. The bench drives one access at a time, leaves an idle cycle between accesses and never holds host_sel across a clock edge. It models each internal space as a sparse memory that returns data within the strobe cycle. Reset is released several cycles before the first access, so the internal synchronised reset has settled before any request.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_e;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_ONCE = 2'd1,
    ARM_SET  = 2'd2
  } arm_e;
endpackage

// File: rtl/ixb_decode.sv
module ixb_decode #(
  parameter int OFF_W = 8
) (
  input  logic                host_sel,
  input  logic [OFF_W-1:0]    host_off,
  output logic                acc_top,
  output logic                acc_ctl,
  output ixb_pkg::reg_e       ridx
);
  import ixb_pkg::*;

  logic valid;
  logic chan;

  always_comb begin
    chan  = host_off[4];
    valid = (host_off[OFF_W-1:5] == '0) && (host_off[1:0] == 2'b00) &&
            (host_off[3:2] != 2'b11);
    ridx    = valid ? reg_e'(host_off[3:2]) : REG_NONE;
    acc_top = host_sel && valid && !chan;
    acc_ctl = host_sel && valid && chan;
  end
endmodule

// File: rtl/ixb_chan.sv
module ixb_chan #(
  parameter int HDW     = 32,
  parameter int IAW     = 16,
  parameter int DW      = 32,
  parameter int ERR_BIT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic               we,
  input  ixb_pkg::reg_e      ridx,
  input  logic [HDW-1:0]     wdata,
  output logic [HDW-1:0]     rsp_data,
  output logic               rsp_err,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic [IAW-1:0]     bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata
);
  import ixb_pkg::*;

  logic [IAW-1:0] pend_q, pend_d;
  arm_e           arm_q, arm_d;
  logic           phase_q, phase_d;
  logic [DW-1:0]  fetch_q, fetch_d;
  logic           erren_q, erren_d;
  logic           upd_en;

  logic is_addr, is_data, is_ctrl, armed;

  always_comb begin
    is_addr = acc && (ridx == REG_ADDR);
    is_data = acc && (ridx == REG_DATA);
    is_ctrl = acc && (ridx == REG_CTRL);
    armed   = (arm_q == ARM_SET);

    bus_rd    = is_data && !we && armed && !phase_q;
    bus_wr    = is_data && we && armed;
    bus_addr  = pend_q;
    bus_wdata = wdata[DW-1:0];
  end

  // next-state logic
  always_comb begin
    pend_d  = pend_q;
    arm_d   = arm_q;
    phase_d = phase_q;
    fetch_d = fetch_q;
    erren_d = erren_q;
    if (is_addr && we) begin
      pend_d  = wdata[IAW-1:0];
      phase_d = 1'b0;
      if (arm_q != ARM_NONE && pend_q == wdata[IAW-1:0])
        arm_d = ARM_SET;
      else
        arm_d = ARM_ONCE;
    end else if (is_data) begin
      if (!armed) begin
        arm_d = ARM_NONE;
      end else if (we) begin
        phase_d = 1'b0;
      end else begin
        phase_d = !phase_q;
        if (!phase_q) fetch_d = bus_rdata;
      end
    end else if (is_ctrl && we) begin
      erren_d = wdata[ERR_BIT];
    end
  end

  // response logic
  always_comb begin
    rsp_data = '0;
    rsp_err  = 1'b0;
    if (is_addr && !we) begin
      rsp_data = HDW'(pend_q);
    end else if (is_ctrl && !we) begin
      rsp_data = HDW'(erren_q) << ERR_BIT;
    end else if (is_data) begin
      if (!armed)
        rsp_err = erren_q;
      else if (!we)
        rsp_data = HDW'(fetch_q);
    end
  end

  assign upd_en = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      arm_q   <= ARM_NONE;
      phase_q <= 1'b0;
      fetch_q <= '0;
      erren_q <= 1'b0;
    end else if (upd_en) begin
      pend_q  <= pend_d;
      arm_q   <= arm_d;
      phase_q <= phase_d;
      fetch_q <= fetch_d;
      erren_q <= erren_d;
    end
  end
endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge #(
  parameter int OFF_W   = 8,
  parameter int HDW     = 32,
  parameter int IAW     = 16,
  parameter int TOP_DW  = 32,
  parameter int CTL_DW  = 8,
  parameter int ERR_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [HDW-1:0]    host_wdata,
  output logic              host_ack,
  output logic [HDW-1:0]    host_rdata,
  output logic              host_err,
  output logic              top_rd,
  output logic              top_wr,
  output logic [IAW-1:0]    top_addr,
  output logic [TOP_DW-1:0] top_wdata,
  input  logic [TOP_DW-1:0] top_rdata,
  output logic              ctl_rd,
  output logic              ctl_wr,
  output logic [IAW-1:0]    ctl_addr,
  output logic [CTL_DW-1:0] ctl_wdata,
  input  logic [CTL_DW-1:0] ctl_rdata
);
  import ixb_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic acc_top, acc_ctl;
  reg_e ridx;

  ixb_decode #(.OFF_W(OFF_W)) u_dec (
    .host_sel (host_sel),
    .host_off (host_off),
    .acc_top  (acc_top),
    .acc_ctl  (acc_ctl),
    .ridx     (ridx)
  );

  logic [HDW-1:0] rsp_top, rsp_ctl;
  logic           err_top, err_ctl;

  ixb_chan #(.HDW(HDW), .IAW(IAW), .DW(TOP_DW), .ERR_BIT(ERR_BIT)) u_top_ch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc       (acc_top),
    .we        (host_we),
    .ridx      (ridx),
    .wdata     (host_wdata),
    .rsp_data  (rsp_top),
    .rsp_err   (err_top),
    .bus_rd    (top_rd),
    .bus_wr    (top_wr),
    .bus_addr  (top_addr),
    .bus_wdata (top_wdata),
    .bus_rdata (top_rdata)
  );

  ixb_chan #(.HDW(HDW), .IAW(IAW), .DW(CTL_DW), .ERR_BIT(ERR_BIT)) u_ctl_ch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc       (acc_ctl),
    .we        (host_we),
    .ridx      (ridx),
    .wdata     (host_wdata),
    .rsp_data  (rsp_ctl),
    .rsp_err   (err_ctl),
    .bus_rd    (ctl_rd),
    .bus_wr    (ctl_wr),
    .bus_addr  (ctl_addr),
    .bus_wdata (ctl_wdata),
    .bus_rdata (ctl_rdata)
  );

  logic           ack_d, err_d;
  logic [HDW-1:0] rdata_d;

  always_comb begin
    ack_d   = host_sel;
    rdata_d = '0;
    err_d   = 1'b0;
    if (acc_top) begin
      rdata_d = rsp_top;
      err_d   = err_top;
    end else if (acc_ctl) begin
      rdata_d = rsp_ctl;
      err_d   = err_ctl;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
      host_err   <= 1'b0;
    end else begin
      host_ack <= ack_d;
      if (host_sel) begin
        host_rdata <= rdata_d;
        host_err   <= err_d;
      end else begin
        host_err   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ixb_bridge_chk.sv
module ixb_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic host_sel,
  input logic host_we,
  input logic host_ack,
  input logic host_err,
  input logic top_rd,
  input logic top_wr,
  input logic ctl_rd,
  input logic ctl_wr
);
  // R2
  ack_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |=> host_ack);

  // R2
  ack_only_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |=> !host_ack);

  // R4
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> host_ack);

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({top_rd, top_wr, ctl_rd, ctl_wr}));

  // R5
  wr_needs_host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_wr || ctl_wr) |-> (host_sel && host_we));

  // R6
  rd_needs_host_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_rd || ctl_rd) |-> (host_sel && !host_we));
endmodule

bind ixb_bridge ixb_bridge_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .host_sel (host_sel),
  .host_we  (host_we),
  .host_ack (host_ack),
  .host_err (host_err),
  .top_rd   (top_rd),
  .top_wr   (top_wr),
  .ctl_rd   (ctl_rd),
  .ctl_wr   (ctl_wr)
);

// File: tb/ixb_bridge_test.sv
`timescale 1ns/1ps
module ixb_bridge_test;
  logic        clk;
  logic        rst_n;
  logic        host_sel, host_we;
  logic [7:0]  host_off;
  logic [31:0] host_wdata;
  logic        host_ack, host_err;
  logic [31:0] host_rdata;
  logic        top_rd, top_wr, ctl_rd, ctl_wr;
  logic [15:0] top_addr, ctl_addr;
  logic [31:0] top_wdata, top_rdata;
  logic [7:0]  ctl_wdata, ctl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ixb_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_we(host_we), .host_off(host_off),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .host_err(host_err),
    .top_rd(top_rd), .top_wr(top_wr), .top_addr(top_addr),
    .top_wdata(top_wdata), .top_rdata(top_rdata),
    .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // sparse internal spaces
  logic [31:0] tmem [int];
  logic [7:0]  cmem [int];

  always @* begin
    top_rdata = tmem.exists(int'(top_addr)) ? tmem[int'(top_addr)] : 32'h0;
    ctl_rdata = cmem.exists(int'(ctl_addr)) ? cmem[int'(ctl_addr)] : 8'h0;
  end

  always @(posedge clk) begin
    if (top_wr) tmem[int'(top_addr)] = top_wdata;
    if (ctl_wr) cmem[int'(ctl_addr)] = ctl_wdata;
  end

  // behavioural reference state, index 0 = top space, 1 = controller space
  int  m_pend  [2];
  int  m_cnt   [2];   // 0 none, 1 one write seen, 2 armed
  bit  m_phase [2];
  int  m_buf   [2];
  bit  m_en    [2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk(host_ack == 1'b0, tag, "idle ack", 32'(host_ack), 32'h0);
    chk({top_rd, top_wr, ctl_rd, ctl_wr} == 4'b0, tag, "idle strobes",
        32'({top_rd, top_wr, ctl_rd, ctl_wr}), 32'h0);
  endtask

  task automatic acc(input bit we, input logic [7:0] off, input logic [31:0] d,
                     input string tag);
    int  c;
    int  idx;
    bit  valid;
    bit  e_rd, e_wr;
    int  e_addr;
    logic [31:0] e_rdata;
    bit  e_err;
    logic [31:0] e_wd;
    @(negedge clk);
    host_sel = 1'b1; host_we = we; host_off = off; host_wdata = d;
    c     = int'(off[4]);
    idx   = int'(off[3:2]);
    valid = (off[7:5] == 3'b0) && (off[1:0] == 2'b0) && (idx != 3);
    e_rd = 0; e_wr = 0; e_rdata = 0; e_err = 0;
    e_addr = m_pend[c];
    e_wd = (c == 1) ? {24'h0, d[7:0]} : d;
    if (valid) begin
      if (idx == 0) begin
        if (we) begin
          if (m_cnt[c] != 0 && m_pend[c] == int'(d[15:0])) m_cnt[c] = 2;
          else m_cnt[c] = 1;
          m_pend[c] = int'(d[15:0]);
          m_phase[c] = 0;
        end else e_rdata = 32'(m_pend[c]);
      end else if (idx == 2) begin
        if (we) m_en[c] = d[15];
        else e_rdata = m_en[c] ? 32'h8000 : 32'h0;
      end else begin
        if (m_cnt[c] != 2) begin
          m_cnt[c] = 0;
          e_err = m_en[c];
        end else if (we) begin
          e_wr = 1; m_phase[c] = 0;
        end else if (!m_phase[c]) begin
          e_rd = 1; e_rdata = 32'(m_buf[c]);
          if (c == 0) m_buf[c] = tmem.exists(m_pend[c]) ? int'(tmem[m_pend[c]]) : 0;
          else        m_buf[c] = cmem.exists(m_pend[c]) ? int'(cmem[m_pend[c]]) : 0;
          m_phase[c] = 1;
        end else begin
          e_rdata = 32'(m_buf[c]); m_phase[c] = 0;
        end
      end
    end
    #1;
    if (c == 0 || !valid) begin
      chk(top_rd == e_rd && top_wr == e_wr, tag, "top strobes",
          32'({top_rd, top_wr}), 32'({e_rd, e_wr}));
      chk(ctl_rd == 0 && ctl_wr == 0, tag, "ctl quiet",
          32'({ctl_rd, ctl_wr}), 32'h0);
      if (e_rd || e_wr)
        chk(top_addr == 16'(e_addr), tag, "top addr", 32'(top_addr), 32'(e_addr));
      if (e_wr)
        chk(top_wdata == e_wd, tag, "top wdata", top_wdata, e_wd);
    end else begin
      chk(ctl_rd == e_rd && ctl_wr == e_wr, tag, "ctl strobes",
          32'({ctl_rd, ctl_wr}), 32'({e_rd, e_wr}));
      chk(top_rd == 0 && top_wr == 0, tag, "top quiet",
          32'({top_rd, top_wr}), 32'h0);
      if (e_rd || e_wr)
        chk(ctl_addr == 16'(e_addr), tag, "ctl addr", 32'(ctl_addr), 32'(e_addr));
      if (e_wr)
        chk(32'(ctl_wdata) == e_wd, tag, "ctl wdata", 32'(ctl_wdata), e_wd);
    end
    @(negedge clk);
    host_sel = 1'b0;
    chk(host_ack == 1'b1, tag, "ack", 32'(host_ack), 32'h1);
    chk(host_err == e_err, tag, "err", 32'(host_err), 32'(e_err));
    if (!we) chk(host_rdata == e_rdata, tag, "rdata", host_rdata, e_rdata);
  endtask

  task automatic set_addr(input logic [7:0] off, input logic [31:0] a, input string tag);
    acc(1, off, a, tag);
    acc(1, off, a, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_pend[i] = 0; m_cnt[i] = 0; m_phase[i] = 0; m_buf[i] = 0; m_en[i] = 0;
    end
    host_sel = 0; host_we = 0; host_off = 0; host_wdata = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R9: reset state
    idle("R9");
    acc(0, 8'h08, 0, "R9");      // error enable clear
    acc(0, 8'h00, 0, "R9");      // address cleared

    // R4: unarmed read, errors disabled -> silent
    acc(0, 8'h04, 0, "R4");
    // R7: error enable bit only
    acc(1, 8'h08, 32'hFFFF_FFFF, "R7");
    acc(0, 8'h08, 0, "R7");
    // R4: unarmed read now errors
    acc(0, 8'h04, 0, "R4");
    // R4: single address write then data write -> error, no strobe
    acc(1, 8'h00, 32'h1234_0010, "R4");
    acc(1, 8'h04, 32'h5555_5555, "R4");
    acc(1, 8'h04, 32'h5555_5555, "R4");

    // R3: double write arms, high bits dropped
    set_addr(8'h00, 32'hABCD_0010, "R3");
    acc(0, 8'h00, 0, "R3");
    // R5: write forwarded
    acc(1, 8'h04, 32'hDEAD_BEEF, "R5");
    // R6: launch returns stale, second returns fresh, third launches again
    acc(0, 8'h04, 0, "R6");
    acc(0, 8'h04, 0, "R6");
    acc(0, 8'h04, 0, "R6");
    // R6: a write resets the read phase
    acc(1, 8'h04, 32'h0BAD_F00D, "R6");
    acc(0, 8'h04, 0, "R6");
    acc(0, 8'h04, 0, "R6");

    // R3: differing values do not arm
    acc(1, 8'h00, 32'h20, "R3");
    acc(1, 8'h00, 32'h21, "R3");
    acc(0, 8'h04, 0, "R3");
    acc(1, 8'h00, 32'h21, "R3");
    acc(1, 8'h00, 32'h21, "R3");
    acc(1, 8'h04, 32'h0000_2121, "R3");

    // R7: control access between address writes keeps the pair
    acc(1, 8'h00, 32'h30, "R7");
    acc(0, 8'h08, 0, "R7");
    acc(1, 8'h00, 32'h30, "R7");
    acc(1, 8'h04, 32'h3030_3030, "R7");
    acc(0, 8'h04, 0, "R7");
    acc(0, 8'h04, 0, "R7");

    // R8: controller channel unaffected by top channel state
    acc(0, 8'h18, 0, "R8");
    acc(1, 8'h14, 32'h0000_00AA, "R8");
    acc(0, 8'h10, 0, "R8");
    acc(1, 8'h04, 32'h4444_4444, "R8");   // top still armed
    // R10 / R5: byte-wide controller space
    set_addr(8'h10, 32'hFFFF_0005, "R10");
    acc(1, 8'h14, 32'h1234_56A5, "R10");
    acc(0, 8'h14, 0, "R10");
    acc(0, 8'h14, 0, "R10");
    acc(1, 8'h18, 32'h0000_8000, "R8");
    acc(1, 8'h10, 32'h7, "R8");
    acc(0, 8'h14, 0, "R8");               // controller errors, top untouched
    acc(0, 8'h08, 0, "R8");

    // R1: undefined offsets
    acc(0, 8'h0C, 0, "R1");
    acc(1, 8'h1C, 32'hFFFF_FFFF, "R1");
    acc(0, 8'h24, 0, "R1");
    acc(1, 8'h06, 32'h1, "R1");
    acc(0, 8'h80, 0, "R1");
    acc(0, 8'h04, 0, "R1");               // top sequencing still intact

    // R6: sweep several addresses with write then read pairs
    for (int k = 0; k < 6; k++) begin
      set_addr(8'h00, 32'(k * 37 + 5), "R6");
      acc(1, 8'h04, 32'hC0DE_0000 + 32'(k), "R6");
      acc(0, 8'h04, 0, "R6");
      acc(0, 8'h04, 0, "R6");
    end
    // R2: ack drop after access
    idle("R2");
    idle("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule